// File: doc/BRIEF.md
# CPU Packet Buffer Handshake Controller

This block sits between a packet router and a small control processor. It owns a shared line RAM split into two packet buffers of 512 lines of 32 bits each. Buffer 0 starts at line 0 and receives packets arriving from the router for the processor. Buffer 1 starts at line 512 and holds packets the processor builds for the router. The processor reaches both buffers through a direct RAM port.

Ownership of each buffer passes between hardware and software through a polled four-phase handshake. The handshake uses two control registers and one status word. A 16-bit line count travels in the upper half of the status word for received packets. It travels in the upper half of the commit control register for transmitted packets. A mode register holds the routing behaviour selection: 0 for slave, 1 for master. Its value is presented to the neighbouring routing logic.

The router side is a pair of valid/ready line streams with start and end markers. The receive stream is written into buffer 0. The transmit stream is read out of buffer 1.

Top module: `pktbuf_handshake`

## Requirements
- R1: After reset the status word reads 0x00000002 (bit 0 clear, bit 1 set, bits 31:16 zero), both control registers read 0, `route_master` is 0 and `rx_ready` is 1.
- R2: Received lines are written to buffer 0 from line 0 upward. A line with `rx_sop` set restarts at line 0. After the line with `rx_eop` is accepted, status bit 0 is set and status bits 31:16 hold the number of lines stored.
- R3: Status bit 0 clears only after the receive-release register (select 1) has bit 0 = 1. `rx_ready` stays 0 from the end of a packet until that register bit has returned to 0.
- R4: A received packet longer than 512 lines keeps only its first 512 lines. Status bits 31:16 then read 512 and status bit 2 is set. Status bit 2 is clear for a packet of 512 lines or fewer.
- R5: A write to the commit register (select 2) with bit 0 = 1 and a line count in bits 31:16 claims buffer 1. Status bit 1 clears one cycle after the register takes the value.
- R6: After a commit of N lines (1 to 512), exactly N lines are sent from buffer lines 512 to 512+N-1 in order. `tx_sop` marks the first line and `tx_eop` marks the last.
- R7: Status bit 1 is set again only after the last line has been sent and the commit register bit 0 has returned to 0. It rises one cycle after the register reads 0.
- R8: A write to the mode register (select 0) sets `route_master` to bit 0 of the written data.
- R9: A commit count of 0 sends no lines. A commit count above 512 sends exactly 512 lines, the last one marked with `tx_eop`.
- R10: While `tx_valid` is 1 and `tx_ready` is 0, the offered line, `tx_sop` and `tx_eop` hold until the line is taken.
- R11: A register write with select value 3 changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 mode, 1 receive release, 2 transmit commit, 3 unused |
| reg_wdata | input | 32 | Register write data |
| status_word | output | 32 | Bit 0 receive packet held, bit 1 transmit buffer free, bit 2 truncated, 31:16 held line count |
| rel_ctrl_rd | output | 32 | Readback of the receive-release register |
| commit_ctrl_rd | output | 32 | Readback of the transmit-commit register |
| route_master | output | 1 | Routing mode selection, 1 = master |
| cpu_ram_we | input | 1 | Processor RAM write enable |
| cpu_ram_addr | input | 10 | Processor RAM line address |
| cpu_ram_wdata | input | 32 | Processor RAM write data |
| cpu_ram_rdata | output | 32 | Processor RAM read data (combinational) |
| rx_valid | input | 1 | Receive line valid |
| rx_ready | output | 1 | Receive line accepted when high with valid |
| rx_data | input | 32 | Receive line data |
| rx_sop | input | 1 | First line of a received packet |
| rx_eop | input | 1 | Last line of a received packet |
| tx_valid | output | 1 | Transmit line valid |
| tx_ready | input | 1 | Transmit line taken when high with valid |
| tx_data | output | 32 | Transmit line data |
| tx_sop | output | 1 | First line of a transmitted packet |
| tx_eop | output | 1 | Last line of a transmitted packet |

## Verification
A register write is taken at the clock edge that ends its strobe cycle, so its readback is due at the next falling edge. The handshake flags react one clock after that. The bench samples each flag both at the falling edge where it must still hold its old value and at the one after, where it must have changed. Status bit 0 and its line count are due at the falling edge just after the edge that accepts the last received line. Each transmitted line is compared by a scoreboard monitor at the falling edge before the rising edge on which valid and ready are both high. Any line offered when the expected queue is empty counts as an error.

// File: rtl/pktbuf_pkg.sv
// Shared types for the packet buffer handshake controller.
// Assumes: consumers size their own vectors from module parameters.
package pktbuf_pkg;

    // Receive side: filling buffer 0, holding a packet for the CPU, or
    // waiting for the release bit to drop before refilling.
    typedef enum logic [1:0] {
        RX_FILL = 2'd0,
        RX_HELD = 2'd1,
        RX_WAIT = 2'd2
    } rx_state_t;

    // Transmit side: buffer 1 free for the CPU, streaming a committed
    // packet, or waiting for the commit bit to drop.
    typedef enum logic [1:0] {
        TX_FREE = 2'd0,
        TX_SEND = 2'd1,
        TX_WAIT = 2'd2
    } tx_state_t;

    // Register select codes.
    localparam logic [1:0] SEL_MODE    = 2'd0;
    localparam logic [1:0] SEL_RELEASE = 2'd1;
    localparam logic [1:0] SEL_COMMIT  = 2'd2;

endpackage

// File: rtl/pktbuf_ram.sv
// Line RAM that holds both packet buffers.
// One processor port with a write and a combinational read, one fill
// write port for the receive engine, and one combinational drain read
// port for the transmit engine.
// Assumes: the fill port and the CPU never write the same line in one
// cycle under the handshake; if they do, the fill port wins.
module pktbuf_ram #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 1024,
    parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              fill_we,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_wdata,
    input  logic [ADDR_W-1:0] drain_addr,
    output logic [DATA_W-1:0] drain_rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Write both ports; the later statement gives the fill port priority.
    always_ff @(posedge clk) begin
        if (cpu_we) begin
            mem[cpu_addr] <= cpu_wdata;
        end
        if (fill_we) begin
            mem[fill_addr] <= fill_wdata;
        end
    end

    // Combinational reads for the processor and the drain engine.
    always_comb begin
        cpu_rdata   = mem[cpu_addr];
        drain_rdata = mem[drain_addr];
    end

endmodule

// File: rtl/pktbuf_rx_fill.sv
// Receive engine: writes router lines into one buffer and holds the
// packet for the CPU until the release handshake completes.
// Assumes: release_req is the release register bit 0, driven by
// software that follows the four-phase protocol.
module pktbuf_rx_fill
    import pktbuf_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned BUF_LINES = 512,
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned BASE_LINE = 0,
    parameter int unsigned CNT_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              release_req,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              held,
    output logic [CNT_W-1:0]  held_lines,
    output logic              truncated
);

    localparam int unsigned IDX_W = $clog2(BUF_LINES + 1);

    rx_state_t        state_q;
    logic [IDX_W-1:0] count_q;
    logic             trunc_q;
    logic [IDX_W-1:0] line_idx;
    logic             room;
    logic             accept;

    // Decode the current line slot and whether it still fits.
    always_comb begin
        in_ready = (state_q == RX_FILL);
        accept   = in_valid && in_ready;
        line_idx = in_sop ? '0 : count_q;
        room     = (line_idx < IDX_W'(BUF_LINES));
        wr_en    = accept && room;
        wr_addr  = ADDR_W'(BASE_LINE) + ADDR_W'(line_idx);
        wr_data  = in_data;
    end

    // Present the held packet's line count and truncation flag.
    always_comb begin
        held       = (state_q == RX_HELD);
        held_lines = held ? CNT_W'(count_q) : '0;
        truncated  = held && trunc_q;
    end

    // Receive handshake state, line counter and truncation tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_FILL;
            count_q <= '0;
            trunc_q <= 1'b0;
        end else begin
            case (state_q)
                RX_FILL: begin
                    if (accept) begin
                        count_q <= room ? (line_idx + IDX_W'(1)) : count_q;
                        trunc_q <= (in_sop ? 1'b0 : trunc_q) | !room;
                        if (in_eop) begin
                            state_q <= RX_HELD;
                        end
                    end
                end
                RX_HELD: begin
                    if (release_req) begin
                        state_q <= RX_WAIT;
                    end
                end
                RX_WAIT: begin
                    if (!release_req) begin
                        state_q <= RX_FILL;
                        count_q <= '0;
                        trunc_q <= 1'b0;
                    end
                end
                default: state_q <= RX_FILL;
            endcase
        end
    end

    // R3: the held flag only drops after the release bit was seen.
    a_r3_release_seen: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(held) |-> $past(release_req))
        else $error("R3: held flag dropped without release request");

    // R3: receiving resumes only while the release bit is low.
    a_r3_no_refill: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ready) |-> !release_req)
        else $error("R3: receive resumed while release still set");

    // R2: a held packet always has at least one line.
    a_r2_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> (held_lines != '0))
        else $error("R2: held packet with zero lines");

    // R2: fill writes stay inside the receive buffer window.
    a_r2_write_window: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ((wr_addr >= ADDR_W'(BASE_LINE)) &&
                   (wr_addr <  ADDR_W'(BASE_LINE + BUF_LINES))))
        else $error("R2: fill write outside buffer");

    // R4: the count never exceeds the buffer and truncation means full.
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (held_lines <= CNT_W'(BUF_LINES)) &&
        (!truncated || (held_lines == CNT_W'(BUF_LINES))))
        else $error("R4: line count beyond buffer size");

endmodule

// File: rtl/pktbuf_tx_drain.sv
// Transmit engine: after a commit, streams the committed number of lines
// from one buffer to the router, then returns the buffer to the CPU once
// the commit bit drops.
// Assumes: the CPU does not write the buffer while it is not free; the
// RAM read port is combinational.
module pktbuf_tx_drain
    import pktbuf_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned BUF_LINES = 512,
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned BASE_LINE = 512,
    parameter int unsigned CNT_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_req,
    input  logic [CNT_W-1:0]  commit_lines,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic              free
);

    localparam int unsigned IDX_W = $clog2(BUF_LINES + 1);

    tx_state_t        state_q;
    logic [IDX_W-1:0] total_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] req_lines;
    logic             last;

    // Clip the requested line count to the buffer size.
    always_comb begin
        if (commit_lines > CNT_W'(BUF_LINES)) begin
            req_lines = IDX_W'(BUF_LINES);
        end else begin
            req_lines = IDX_W'(commit_lines);
        end
    end

    // Drive the stream from the current read index.
    always_comb begin
        free      = (state_q == TX_FREE);
        out_valid = (state_q == TX_SEND);
        last      = (idx_q == (total_q - IDX_W'(1)));
        rd_addr   = ADDR_W'(BASE_LINE) + ADDR_W'(idx_q);
        out_data  = rd_data;
        out_sop   = out_valid && (idx_q == '0);
        out_eop   = out_valid && last;
    end

    // Transmit handshake state and read index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_FREE;
            total_q <= '0;
            idx_q   <= '0;
        end else begin
            case (state_q)
                TX_FREE: begin
                    if (commit_req) begin
                        total_q <= req_lines;
                        idx_q   <= '0;
                        state_q <= (req_lines == '0) ? TX_WAIT : TX_SEND;
                    end
                end
                TX_SEND: begin
                    if (out_ready) begin
                        if (last) begin
                            state_q <= TX_WAIT;
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end
                end
                TX_WAIT: begin
                    if (!commit_req) begin
                        state_q <= TX_FREE;
                    end
                end
                default: state_q <= TX_FREE;
            endcase
        end
    end

    // R5: the free flag drops only in answer to a commit.
    a_r5_claim_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(free) |-> $past(commit_req))
        else $error("R5: buffer claimed without commit");

    // R7: the free flag returns only after streaming and commit low.
    a_r7_free_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(free) |-> (!commit_req && !$past(out_valid)))
        else $error("R7: buffer freed too early");

    // R10: an offered line holds its markers until taken.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sop) && $stable(out_eop)))
        else $error("R10: offered line changed before accept");

    // R6: nothing follows the last line of a packet.
    a_r6_eop_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_eop) |=> !out_valid)
        else $error("R6: line sent after end marker");

endmodule

// File: rtl/pktbuf_handshake.sv
// Top of the CPU packet buffer handshake controller. Holds the mode,
// release and commit registers, builds the status word and connects the
// receive and transmit engines to the shared line RAM.
// Assumes: software follows the four-phase protocol on both buffers.
module pktbuf_handshake
    import pktbuf_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned BUF_LINES = 512,
    parameter int unsigned CNT_W     = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              reg_we,
    input  logic [1:0]                        reg_sel,
    input  logic [31:0]                       reg_wdata,
    output logic [31:0]                       status_word,
    output logic [31:0]                       rel_ctrl_rd,
    output logic [31:0]                       commit_ctrl_rd,
    output logic                              route_master,
    input  logic                              cpu_ram_we,
    input  logic [$clog2(2*BUF_LINES)-1:0]    cpu_ram_addr,
    input  logic [DATA_W-1:0]                 cpu_ram_wdata,
    output logic [DATA_W-1:0]                 cpu_ram_rdata,
    input  logic                              rx_valid,
    output logic                              rx_ready,
    input  logic [DATA_W-1:0]                 rx_data,
    input  logic                              rx_sop,
    input  logic                              rx_eop,
    output logic                              tx_valid,
    input  logic                              tx_ready,
    output logic [DATA_W-1:0]                 tx_data,
    output logic                              tx_sop,
    output logic                              tx_eop
);

    localparam int unsigned NUM_BUFS = 2;
    localparam int unsigned DEPTH    = NUM_BUFS * BUF_LINES;
    localparam int unsigned ADDR_W   = $clog2(DEPTH);
    localparam int unsigned RX_BASE  = 0;
    localparam int unsigned TX_BASE  = BUF_LINES;
    localparam int unsigned PAD_W    = 32 - CNT_W - 3;

    logic              mode_q;
    logic [31:0]       rel_q;
    logic [31:0]       commit_q;
    logic              fill_we;
    logic [ADDR_W-1:0] fill_addr;
    logic [DATA_W-1:0] fill_wdata;
    logic [ADDR_W-1:0] drain_addr;
    logic [DATA_W-1:0] drain_rdata;
    logic              rx_held;
    logic [CNT_W-1:0]  rx_lines;
    logic              rx_trunc;
    logic              tx_free;

    // Software-visible control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= 1'b0;
            rel_q    <= '0;
            commit_q <= '0;
        end else if (reg_we) begin
            case (reg_sel)
                SEL_MODE:    mode_q   <= reg_wdata[0];
                SEL_RELEASE: rel_q    <= reg_wdata;
                SEL_COMMIT:  commit_q <= reg_wdata;
                default:     ;
            endcase
        end
    end

    // Readback and status assembly.
    always_comb begin
        rel_ctrl_rd    = rel_q;
        commit_ctrl_rd = commit_q;
        route_master   = mode_q;
        status_word    = {rx_lines, {PAD_W{1'b0}}, rx_trunc, tx_free, rx_held};
    end

    pktbuf_ram #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) ram_i (
        .clk         (clk),
        .cpu_we      (cpu_ram_we),
        .cpu_addr    (cpu_ram_addr),
        .cpu_wdata   (cpu_ram_wdata),
        .cpu_rdata   (cpu_ram_rdata),
        .fill_we     (fill_we),
        .fill_addr   (fill_addr),
        .fill_wdata  (fill_wdata),
        .drain_addr  (drain_addr),
        .drain_rdata (drain_rdata)
    );

    pktbuf_rx_fill #(
        .DATA_W    (DATA_W),
        .BUF_LINES (BUF_LINES),
        .ADDR_W    (ADDR_W),
        .BASE_LINE (RX_BASE),
        .CNT_W     (CNT_W)
    ) rx_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (rx_valid),
        .in_ready    (rx_ready),
        .in_data     (rx_data),
        .in_sop      (rx_sop),
        .in_eop      (rx_eop),
        .release_req (rel_q[0]),
        .wr_en       (fill_we),
        .wr_addr     (fill_addr),
        .wr_data     (fill_wdata),
        .held        (rx_held),
        .held_lines  (rx_lines),
        .truncated   (rx_trunc)
    );

    pktbuf_tx_drain #(
        .DATA_W    (DATA_W),
        .BUF_LINES (BUF_LINES),
        .ADDR_W    (ADDR_W),
        .BASE_LINE (TX_BASE),
        .CNT_W     (CNT_W)
    ) tx_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .commit_req   (commit_q[0]),
        .commit_lines (commit_q[31:32-CNT_W]),
        .rd_addr      (drain_addr),
        .rd_data      (drain_rdata),
        .out_valid    (tx_valid),
        .out_ready    (tx_ready),
        .out_data     (tx_data),
        .out_sop      (tx_sop),
        .out_eop      (tx_eop),
        .free         (tx_free)
    );

    // R1: first cycle out of reset shows the idle handshake state.
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> ((status_word == 32'h0000_0002) && (rel_ctrl_rd == '0) &&
                           (commit_ctrl_rd == '0) && !route_master))
        else $error("R1: wrong state after reset");

    // R11: a write with the unused select leaves every register alone.
    a_r11_unused_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && (reg_sel == 2'd3)) |=>
            ($stable(rel_ctrl_rd) && $stable(commit_ctrl_rd) && $stable(route_master)))
        else $error("R11: unused select changed a register");

endmodule

// File: tb/pktbuf_handshake_tb.sv
// Scoreboard bench for the packet buffer handshake controller.
module pktbuf_handshake_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] status_word, rel_ctrl_rd, commit_ctrl_rd;
    logic        route_master;
    logic        cpu_ram_we = 1'b0;
    logic [9:0]  cpu_ram_addr = '0;
    logic [31:0] cpu_ram_wdata = '0;
    logic [31:0] cpu_ram_rdata;
    logic        rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0;
    logic [31:0] rx_data = '0;
    logic        rx_ready;
    logic        tx_valid, tx_sop, tx_eop;
    logic        tx_ready = 1'b0;
    logic [31:0] tx_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [33:0] exp_q[$];

    always #2 clk = ~clk;

    pktbuf_handshake dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .status_word(status_word), .rel_ctrl_rd(rel_ctrl_rd),
        .commit_ctrl_rd(commit_ctrl_rd), .route_master(route_master),
        .cpu_ram_we(cpu_ram_we), .cpu_ram_addr(cpu_ram_addr),
        .cpu_ram_wdata(cpu_ram_wdata), .cpu_ram_rdata(cpu_ram_rdata),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .rx_sop(rx_sop), .rx_eop(rx_eop), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic ram_write(input int addr, input logic [31:0] data);
        @(negedge clk);
        cpu_ram_we = 1'b1; cpu_ram_addr = 10'(addr); cpu_ram_wdata = data;
        @(negedge clk);
        cpu_ram_we = 1'b0;
    endtask

    task automatic ram_expect(input int addr, input logic [31:0] exp, input string req);
        @(negedge clk);
        cpu_ram_addr = 10'(addr);
        #1;
        chk(cpu_ram_rdata == exp, req, cpu_ram_rdata, exp);
    endtask

    function automatic logic [31:0] rx_word(input int seed, input int i);
        return 32'hA000_0000 + 32'(seed << 12) + 32'(i);
    endfunction

    function automatic logic [31:0] tx_word(input int seed, input int i);
        return 32'h5000_0000 + 32'(seed << 12) + 32'(i * 3);
    endfunction

    // Driver for the receive stream; returns with the packet accepted.
    task automatic send_rx(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = rx_word(seed, i);
            rx_sop = (i == 0); rx_eop = (i == n - 1);
            while (!rx_ready) @(negedge clk);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0;
    endtask

    // Release buffer 0 with the four-phase handshake, checking each phase.
    task automatic release_rx();
        wr_reg(2'd1, 32'h1);
        chk(status_word[0] == 1'b1, "R3 flag held until release seen", status_word[0], 1);
        @(negedge clk);
        chk(status_word[0] == 1'b0, "R3 flag clears after release", status_word[0], 0);
        repeat (3) @(negedge clk);
        chk(rx_ready == 1'b0, "R3 no refill while release high", rx_ready, 0);
        wr_reg(2'd1, 32'h0);
        @(negedge clk);
        chk(rx_ready == 1'b1, "R3 receive resumes after release low", rx_ready, 1);
    endtask

    // Driver for the transmit side: fill buffer 1 and queue expectations.
    task automatic load_tx(input int n, input int sent, input int seed);
        for (int i = 0; i < n; i++) ram_write(512 + i, tx_word(seed, i));
        for (int i = 0; i < sent; i++)
            exp_q.push_back({tx_word(seed, i), (i == 0), (i == sent - 1)});
    endtask

    task automatic commit_tx(input int cnt, input string req);
        wr_reg(2'd2, {16'(cnt), 16'h0001});
        chk(status_word[1] == 1'b1, "R5 free flag before commit seen", status_word[1], 1);
        @(negedge clk);
        chk(status_word[1] == 1'b0, "R5 free flag clears on commit", status_word[1], 0);
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(tx_valid == 1'b0, {req, " stream stops"}, tx_valid, 0);
        chk(status_word[1] == 1'b0, "R7 still claimed while commit high", status_word[1], 0);
        wr_reg(2'd2, 32'h0);
        chk(status_word[1] == 1'b0, "R7 not freed in the commit-low cycle", status_word[1], 0);
        @(negedge clk);
        chk(status_word[1] == 1'b1, "R7 freed after commit low", status_word[1], 1);
    endtask

    // Monitor: drive a stalling ready pattern and pop/compare each taken line.
    initial begin
        int cyc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            tx_ready = (cyc % 3 != 2);
            if (rst_n && tx_valid && tx_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6/R9 unexpected transmit line", {tx_data, tx_sop, tx_eop}, 0);
                end else begin
                    logic [33:0] e;
                    e = exp_q.pop_front();
                    chk({tx_data, tx_sop, tx_eop} == e, "R6/R10 transmit line",
                        {tx_data, tx_sop, tx_eop}, e);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog expired", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(status_word == 32'h0000_0002, "R1 status after reset", status_word, 32'h2);
        chk(rel_ctrl_rd == 0, "R1 release reg after reset", rel_ctrl_rd, 0);
        chk(commit_ctrl_rd == 0, "R1 commit reg after reset", commit_ctrl_rd, 0);
        chk(route_master == 1'b0, "R1 mode after reset", route_master, 0);
        chk(rx_ready == 1'b1 && tx_valid == 1'b0, "R1 stream idle after reset",
            {rx_ready, tx_valid}, 2'b10);

        // R8 mode register
        wr_reg(2'd0, 32'h1);
        chk(route_master == 1'b1, "R8 master mode", route_master, 1);
        // R11 unused select
        wr_reg(2'd3, 32'hFFFF_FFFF);
        chk(rel_ctrl_rd == 0 && commit_ctrl_rd == 0 && route_master == 1'b1,
            "R11 unused select ignored", {rel_ctrl_rd[0], commit_ctrl_rd[0], route_master}, 3'b001);
        wr_reg(2'd0, 32'h0);
        chk(route_master == 1'b0, "R8 slave mode", route_master, 0);

        // R2 short packet
        send_rx(5, 1);
        chk(status_word[0] == 1'b1, "R2 packet held", status_word[0], 1);
        chk(status_word[31:16] == 16'd5, "R2 line count", status_word[31:16], 5);
        chk(status_word[2] == 1'b0, "R4 no truncation on short packet", status_word[2], 0);
        chk(rx_ready == 1'b0, "R3 not ready while held", rx_ready, 0);
        for (int i = 0; i < 5; i++) ram_expect(i, rx_word(1, i), "R2 buffer 0 contents");
        repeat (5) @(negedge clk);
        chk(status_word[0] == 1'b1, "R3 flag stays without release", status_word[0], 1);
        release_rx();

        // R4 oversize packet
        send_rx(515, 2);
        chk(status_word[31:16] == 16'd512, "R4 count capped", status_word[31:16], 512);
        chk(status_word[2] == 1'b1, "R4 truncation flagged", status_word[2], 1);
        ram_expect(0, rx_word(2, 0), "R4 first line kept");
        ram_expect(511, rx_word(2, 511), "R4 last stored line");
        ram_expect(512, 32'h0, "R4 no write past buffer 0");
        release_rx();

        // R2 exactly full packet, then a short one
        send_rx(512, 3);
        chk(status_word[31:16] == 16'd512 && status_word[2] == 1'b0,
            "R4 full packet not truncated", status_word[31:16], 512);
        release_rx();
        send_rx(2, 4);
        chk(status_word[31:16] == 16'd2 && status_word[2] == 1'b0,
            "R2 count restarts after truncation", status_word[31:16], 2);
        ram_expect(1, rx_word(4, 1), "R2 line written from 0 upward");
        release_rx();

        // R6 transmit a committed packet
        load_tx(6, 6, 5);
        commit_tx(6, "R6");
        load_tx(1, 1, 6);
        commit_tx(1, "R6 single line");

        // R9 zero-length and clipped commits
        commit_tx(0, "R9 zero length");
        load_tx(512, 512, 7);
        commit_tx(600, "R9 clipped");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule